// File: doc/BRIEF.md
# DRAM Access and Refresh Sequencer

This block is the timing heart of a single-port DRAM controller. It decides, cycle by cycle, whether the DRAM array serves a processor access or a refresh. It then drives the active-low row and column strobes, an active-high grant, and a data-transfer acknowledge that has a separate output enable. It also drives a select code that steers an external address multiplexer to the row address, the column address or the refresh address.

All timing runs on a clock at twice the rate of the nominal bus clock. A phase bit separates the half-periods. In the "rise" slot (phase 0) the access request is sampled. In the "fall" slot (phase 1) the refresh request is sampled. Every delay below is counted in these half-periods (one half-period is one clock cycle of `clk`). Three static pins set the behaviour: one selects a short or long RAS precharge, one selects a half or full row-address hold, and one holds the strobe open for page-mode bursts. The refresh request arrives as a level from an external pending counter. That counter is decremented by the one-cycle refresh-done strobe.

Top module: `dram_seq_top`

## Requirements
- R1: After reset, ras_n and cas_n are 1, gnt is 0, dtack_oe is 0, dtack_n is 1, mux_sel is row (code 0), rfsh_done is 0 and cp_phase is 0. The precharge timer counts as satisfied, so an access may start in the first rise slot.
- R2: An access starts only from idle, with precharge satisfied, in a cycle with cp_phase 0 and req_n low. In the next cycle ras_n goes low and gnt goes high together, and cp_phase reads 1 in that cycle.
- R3: In an access, cas_n goes low exactly 3 cycles after ras_n went low, whatever the value of hold_half.
- R4: In an access, mux_sel changes from row (code 0) to column (code 1) 2 cycles after ras_n falls when hold_half is 0, and 1 cycle after when hold_half is 1.
- R5: With page_n high, ras_n rises exactly 8 cycles after it fell. dtack_n goes low in that same cycle. dtack_oe stays high for the whole access.
- R6: With page_n low at the 8-cycle point, ras_n stays low until page_n or req_n goes high, whichever comes first. It rises in the cycle after that input is sampled high.
- R7: While gnt is high, req_n sampled high ends the access. In the next cycle ras_n and cas_n are 1, gnt is 0 and dtack_oe is 0. Until then, gnt, cas_n and dtack_n hold their values.
- R8: After ras_n rises, it stays high for at least 8 cycles when pre_short was 0 at the rise, and at least 6 cycles when pre_short was 1.
- R9: A refresh starts from idle, with precharge satisfied, in a cycle with cp_phase 1 and rfsh_req high. mux_sel shows refresh (code 2) from the next cycle on. ras_n falls one cycle later and stays low exactly 8 cycles. During a refresh, cas_n stays 1 and gnt and dtack_oe stay 0.
- R10: rfsh_done is high for exactly one cycle: the cycle in which ras_n rises at the end of a refresh.
- R11: When both requests are pending, the one whose slot comes first after precharge is served first. req_n is ignored while a refresh runs, and a held request is served at the first rise slot after that refresh and its precharge.
- R12: A refresh request that arrives while gnt is high waits until the access ends. Pending refreshes then run back to back, each separated by its precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | 1 | Access request, active low |
| page_n | input | 1 | Page-mode hold, active low |
| pre_short | input | 1 | 1: precharge 6 cycles, 0: precharge 8 cycles |
| hold_half | input | 1 | 1: row held 1 cycle, 0: row held 2 cycles |
| rfsh_req | input | 1 | Refresh pending, level |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| gnt | output | 1 | Access granted |
| dtack_n | output | 1 | Transfer acknowledge, active low |
| dtack_oe | output | 1 | Enable for the dtack_n driver |
| mux_sel | output | 2 | Address select: 0 row, 1 column, 2 refresh |
| rfsh_done | output | 1 | One-cycle pulse at the end of a refresh |
| cp_phase | output | 1 | Half-period phase: 0 rise slot, 1 fall slot |

## Verification
The bench targets the slot at which each request is sampled. A design that mixed up the phases would start an access half a bus cycle early or late, and would shift every strobe edge relative to the reference. Precharge is tested with a request already waiting as the strobe rises, under both lengths. A timer that is off by one would reassert RAS a cycle too soon. Page mode is ended once by the page input and once by the request, so a strobe held by only one of the two conditions shows up. Refresh is raised together with an access, during an access, and several times during a long page burst. These runs catch a grant that leaks into a refresh, a refresh that cuts into an access, and a pending refresh that is lost.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_RF   = 2'd2
  } seq_st_t;

  typedef enum logic [1:0] {
    MUX_ROW = 2'd0,
    MUX_COL = 2'd1,
    MUX_REF = 2'd2
  } mux_sel_t;

endpackage

// File: rtl/dram_pre_timer.sv
module dram_pre_timer #(
  parameter int PRE_LONG  = 4,
  parameter int PRE_SHORT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic sel_short,
  output logic ok
);
  localparam int W = $clog2(2 * PRE_LONG + 1);
  localparam logic [W-1:0] LD_LONG  = W'(2 * PRE_LONG - 1);
  localparam logic [W-1:0] LD_SHORT = W'(2 * PRE_SHORT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= sel_short ? LD_SHORT : LD_LONG;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign ok = (cnt_q == '0);

  p_load_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    load |=> !ok);

endmodule

// File: rtl/dram_arb.sv
module dram_arb (
  input  logic idle,
  input  logic pre_ok,
  input  logic ph,
  input  logic req_n,
  input  logic rfsh_req,
  output logic start_acc,
  output logic start_rf
);
  // Access requests are sampled in the rise slot, refresh in the fall slot.
  // The slot that comes first after precharge wins.
  always_comb begin
    start_acc = idle && pre_ok && !ph && !req_n;
    start_rf  = idle && pre_ok &&  ph && rfsh_req;
  end
endmodule

// File: rtl/dram_seq_core.sv
module dram_seq_core import dram_seq_pkg::*; #(
  parameter int CNT_W    = 4,
  parameter int RAS_HALF = 8,
  parameter int CAS_DLY  = 3,
  parameter int COL_FULL = 2,
  parameter int COL_HALF = 1,
  parameter int MIN_PRE  = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ph,
  input  logic       start_acc,
  input  logic       start_rf,
  input  logic       req_n,
  input  logic       page_n,
  input  logic       hldrow,
  output logic       idle,
  output logic       ras_neg,
  output logic       ras_n,
  output logic       cas_n,
  output logic       gnt,
  output logic       dtack_oe,
  output logic       dtack_n,
  output logic [1:0] mux_sel,
  output logic       rfsh_done
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] K_RAS   = CNT_W'(RAS_HALF);
  localparam logic [CNT_W-1:0] K_CAS   = CNT_W'(CAS_DLY);
  localparam logic [CNT_W-1:0] K_COLF  = CNT_W'(COL_FULL);
  localparam logic [CNT_W-1:0] K_COLH  = CNT_W'(COL_HALF);

  seq_st_t          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             on_q, on_d;
  logic             neg_d, done_d;
  logic             ras_d, cas_d, gnt_d, oe_d, dt_d;
  mux_sel_t         mux_d, mux_q;

  // next-state
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    on_d   = on_q;
    neg_d  = 1'b0;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_acc) begin
          st_d  = ST_ACC;
          cnt_d = '0;
          on_d  = 1'b1;
        end else if (start_rf) begin
          st_d  = ST_RF;
          cnt_d = '0;
        end
      end
      ST_ACC: begin
        if (req_n) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
          on_d  = 1'b0;
          neg_d = on_q;
        end else begin
          if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
          if (on_q && (cnt_d >= K_RAS) && page_n) begin
            on_d  = 1'b0;
            neg_d = 1'b1;
          end
        end
      end
      ST_RF: begin
        if (cnt_q == K_RAS) begin
          st_d   = ST_IDLE;
          cnt_d  = '0;
          neg_d  = 1'b1;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // output decode from next state, registered below
  always_comb begin
    ras_d = 1'b1;
    cas_d = 1'b1;
    gnt_d = 1'b0;
    oe_d  = 1'b0;
    dt_d  = 1'b1;
    mux_d = MUX_ROW;
    unique case (st_d)
      ST_ACC: begin
        ras_d = !on_d;
        gnt_d = 1'b1;
        oe_d  = 1'b1;
        cas_d = !(cnt_d >= K_CAS);
        dt_d  = !(cnt_d >= K_RAS);
        if (cnt_d >= (hldrow ? K_COLH : K_COLF)) mux_d = MUX_COL;
      end
      ST_RF: begin
        mux_d = MUX_REF;
        ras_d = (cnt_d == '0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      on_q      <= 1'b0;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      gnt       <= 1'b0;
      dtack_oe  <= 1'b0;
      dtack_n   <= 1'b1;
      mux_q     <= MUX_ROW;
      rfsh_done <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      on_q      <= on_d;
      ras_n     <= ras_d;
      cas_n     <= cas_d;
      gnt       <= gnt_d;
      dtack_oe  <= oe_d;
      dtack_n   <= dt_d;
      mux_q     <= mux_d;
      rfsh_done <= done_d;
    end
  end

  assign mux_sel = mux_q;
  assign idle    = (st_q == ST_IDLE);
  assign ras_neg = neg_d;

  // checker state: cycles the strobe has been high
  logic [3:0] hi_run;
  always_ff @(posedge clk) begin
    if (rst)                 hi_run <= 4'hf;
    else if (!ras_n)         hi_run <= '0;
    else if (hi_run != 4'hf) hi_run <= hi_run + 1'b1;
  end

  p_grant_slot_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(gnt) |-> (!ras_n && ph));
  p_cas_in_ras_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(cas_n) |-> !ras_n);
  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    (gnt && req_n) |=> (!gnt && ras_n && cas_n && !dtack_oe));
  p_precharge_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (hi_run >= 4'(MIN_PRE)));
  p_cas_only_access_r9: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> gnt);
  p_refresh_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (mux_sel == MUX_REF) |-> (cas_n && !gnt && !dtack_oe));
  p_done_at_rise_r10: assert property (@(posedge clk) disable iff (rst)
    rfsh_done |-> $rose(ras_n));

endmodule

// File: rtl/dram_seq_top.sv
module dram_seq_top #(
  parameter int PRE_LONG  = 4,
  parameter int PRE_SHORT = 3,
  parameter int RAS_CP    = 4,
  parameter int CNT_W     = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_n,
  input  logic       page_n,
  input  logic       pre_short,
  input  logic       hold_half,
  input  logic       rfsh_req,
  output logic       ras_n,
  output logic       cas_n,
  output logic       gnt,
  output logic       dtack_n,
  output logic       dtack_oe,
  output logic [1:0] mux_sel,
  output logic       rfsh_done,
  output logic       cp_phase
);
  localparam int RAS_HALF = 2 * RAS_CP;

  logic ph;
  logic idle, pre_ok, ras_neg, start_acc, start_rf;

  always_ff @(posedge clk) begin
    if (rst) ph <= 1'b0;
    else     ph <= ~ph;
  end
  assign cp_phase = ph;

  dram_pre_timer #(.PRE_LONG(PRE_LONG), .PRE_SHORT(PRE_SHORT)) u_pre (
    .clk(clk), .rst(rst), .load(ras_neg), .sel_short(pre_short), .ok(pre_ok)
  );

  dram_arb u_arb (
    .idle(idle), .pre_ok(pre_ok), .ph(ph), .req_n(req_n), .rfsh_req(rfsh_req),
    .start_acc(start_acc), .start_rf(start_rf)
  );

  dram_seq_core #(
    .CNT_W(CNT_W), .RAS_HALF(RAS_HALF), .CAS_DLY(3), .COL_FULL(2),
    .COL_HALF(1), .MIN_PRE(2 * PRE_SHORT)
  ) u_core (
    .clk(clk), .rst(rst), .ph(ph), .start_acc(start_acc), .start_rf(start_rf),
    .req_n(req_n), .page_n(page_n), .hldrow(hold_half), .idle(idle),
    .ras_neg(ras_neg), .ras_n(ras_n), .cas_n(cas_n), .gnt(gnt),
    .dtack_oe(dtack_oe), .dtack_n(dtack_n), .mux_sel(mux_sel),
    .rfsh_done(rfsh_done)
  );

endmodule

// File: tb/dram_seq_top_tb_top.sv
module dram_seq_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_n = 1'b1, page_n = 1'b1, pre_short = 1'b0, hold_half = 1'b0, rfsh_req = 1'b0;
  logic ras_n, cas_n, gnt, dtack_n, dtack_oe, rfsh_done, cp_phase;
  logic [1:0] mux_sel;

  always #5 clk = ~clk;

  dram_seq_top dut_i (
    .clk(clk), .rst(rst), .req_n(req_n), .page_n(page_n), .pre_short(pre_short),
    .hold_half(hold_half), .rfsh_req(rfsh_req), .ras_n(ras_n), .cas_n(cas_n),
    .gnt(gnt), .dtack_n(dtack_n), .dtack_oe(dtack_oe), .mux_sel(mux_sel),
    .rfsh_done(rfsh_done), .cp_phase(cp_phase)
  );

  int checks = 0;
  int errs   = 0;

  // behavioural reference model
  int n = 0, mode = 0, t = 0, neg_edge = -1000, pre_len = 0;
  bit ras_on = 0, ph_m = 0;
  bit e_ras = 1, e_cas = 1, e_gnt = 0, e_oe = 0, e_dt = 1, e_done = 0;
  int e_mux = 0;

  always @(posedge clk) begin
    if (rst) begin
      mode = 0; t = 0; ras_on = 0; neg_edge = -1000; pre_len = 0; ph_m = 0; e_done = 0;
    end else begin
      bit pre_ok;
      pre_ok = (n - neg_edge) >= pre_len;
      e_done = 0;
      case (mode)
        0: if (pre_ok && !ph_m && !req_n) begin mode = 1; t = 0; ras_on = 1; end
           else if (pre_ok && ph_m && rfsh_req) begin mode = 2; t = 0; end
        1: if (req_n) begin
             if (ras_on) begin neg_edge = n; pre_len = pre_short ? 6 : 8; end
             mode = 0; t = 0; ras_on = 0;
           end else begin
             if (t < 15) t++;
             if (ras_on && t >= 8 && page_n) begin
               ras_on = 0; neg_edge = n; pre_len = pre_short ? 6 : 8;
             end
           end
        default: if (t == 8) begin
             mode = 0; t = 0; neg_edge = n; pre_len = pre_short ? 6 : 8; e_done = 1;
           end else t++;
      endcase
      ph_m = !ph_m;
    end
    n++;
    e_ras = !((mode == 1 && ras_on) || (mode == 2 && t >= 1));
    e_gnt = (mode == 1);
    e_oe  = (mode == 1);
    e_cas = !(mode == 1 && t >= 3);
    e_dt  = !(mode == 1 && t >= 8);
    e_mux = (mode == 2) ? 2 : ((mode == 1 && t >= (hold_half ? 1 : 2)) ? 1 : 0);
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, n);
    end
  endtask

  // event tracking from the ports
  int cyc = 0, pend = 0, done_cnt = 0;
  int ras_fall = 0, ras_rise = 0, width = 0, gap = 0, cas_lat = -1, col_lat = -1, dt_fall = -1;
  int rf_bad = 0;
  bit p_ras = 1, p_cas = 1, p_dt = 1;
  int p_mux = 0;

  task automatic tick(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      cyc++;
      checks++;
      if (ras_n !== e_ras || cas_n !== e_cas || gnt !== e_gnt || dtack_oe !== e_oe ||
          dtack_n !== e_dt || int'(mux_sel) != e_mux || rfsh_done !== e_done ||
          cp_phase !== ph_m) begin
        errs++;
        $display("FAIL R2/R3/R4/R5/R6/R7/R8/R9/R10/R11/R12 cycle %0d actual ras=%b cas=%b gnt=%b oe=%b dt=%b mux=%0d done=%b ph=%b expected ras=%b cas=%b gnt=%b oe=%b dt=%b mux=%0d done=%b ph=%b",
          n, ras_n, cas_n, gnt, dtack_oe, dtack_n, mux_sel, rfsh_done, cp_phase,
          e_ras, e_cas, e_gnt, e_oe, e_dt, e_mux, e_done, ph_m);
      end
      if (p_ras && !ras_n) begin ras_fall = cyc; gap = cyc - ras_rise; end
      if (!p_ras && ras_n) begin ras_rise = cyc; width = cyc - ras_fall; end
      if (p_cas && !cas_n) cas_lat = cyc - ras_fall;
      if (p_mux == 0 && mux_sel == 2'd1) col_lat = cyc - ras_fall;
      if (p_dt && !dtack_n) dt_fall = cyc;
      if (mux_sel == 2'd2 && (gnt || !cas_n)) rf_bad++;
      if (rfsh_done) done_cnt++;
      p_ras = ras_n; p_cas = cas_n; p_dt = dtack_n; p_mux = int'(mux_sel);
      if (e_done && pend > 0) pend--;
      rfsh_req = (pend > 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    int d0;
    tick(4);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk("R1 ras_n", ras_n, 1); chk("R1 cas_n", cas_n, 1); chk("R1 gnt", gnt, 0);
    chk("R1 dtack_oe", dtack_oe, 0); chk("R1 mux_sel", mux_sel, 0);
    tick(1);
    // R2 R3 R4 R5: plain access, full row hold, long precharge
    req_n = 1'b0;
    tick(14);
    chk("R5 ras width", width, 8);
    chk("R3 cas latency", cas_lat, 3);
    chk("R4 col latency full hold", col_lat, 2);
    chk("R5 dtack with ras rise", dt_fall, ras_rise);
    chk("R7 gnt held", gnt, 1);
    req_n = 1'b1;
    tick(1);
    chk("R7 release", {gnt, ras_n, cas_n, dtack_oe}, 4'b0110);
    // R8: request waiting through long precharge, half row hold
    pre_short = 1'b1; hold_half = 1'b1; req_n = 1'b0;
    tick(24);
    chk("R8 long precharge gap", gap >= 8, 1);
    chk("R4 col latency half hold", col_lat, 1);
    req_n = 1'b1; tick(1); req_n = 1'b0;
    tick(10);
    chk("R8 short precharge gap", gap >= 6, 1);
    chk("R2 granted after gap", gnt, 1);
    req_n = 1'b1; tick(1);
    // R6: page mode ended by page_n
    pre_short = 1'b0; hold_half = 1'b0; page_n = 1'b0; req_n = 1'b0;
    tick(30);
    chk("R6 ras held low", ras_n, 0);
    page_n = 1'b1; tick(2);
    chk("R6 ras released by page", ras_n, 1);
    chk("R7 gnt held after page", gnt, 1);
    req_n = 1'b1; tick(1);
    // R6: page mode ended by req_n
    page_n = 1'b0; req_n = 1'b0;
    tick(30);
    req_n = 1'b1; tick(1); page_n = 1'b1;
    chk("R6 ras released by req", ras_n, 1);
    chk("R7 gnt off", gnt, 0);
    // R9 R10: lone refresh
    tick(12);
    d0 = done_cnt; pend = 1; rfsh_req = 1'b1;
    tick(14);
    chk("R9 refresh ras width", width, 8);
    chk("R9 no grant or cas in refresh", rf_bad, 0);
    chk("R10 one done pulse", done_cnt - d0, 1);
    // R11: both together
    tick(12);
    d0 = done_cnt; pend = 1; rfsh_req = 1'b1; req_n = 1'b0;
    tick(40);
    chk("R11 refresh served", done_cnt - d0, 1);
    chk("R11 access served", gnt, 1);
    req_n = 1'b1; tick(12);
    // R11: request arriving during refresh is ignored then served
    pend = 1; rfsh_req = 1'b1;
    tick(3);
    chk("R9 refresh select", mux_sel, 2);
    req_n = 1'b0; tick(4);
    chk("R11 req ignored in refresh", gnt, 0);
    tick(20);
    chk("R11 req served after refresh", gnt, 1);
    req_n = 1'b1; tick(12);
    // R12: refreshes wait behind a long page access
    page_n = 1'b0; req_n = 1'b0; tick(6);
    d0 = done_cnt; pend = 3; rfsh_req = 1'b1;
    tick(20);
    chk("R12 no refresh during access", done_cnt - d0, 0);
    chk("R12 access kept", gnt, 1);
    req_n = 1'b1; page_n = 1'b1;
    tick(80);
    chk("R12 burst refresh count", done_cnt - d0, 3);
    chk("R9 burst clean", rf_bad, 0);
    // R7: early release right after grant
    req_n = 1'b0;
    for (int i = 0; i < 20 && !gnt; i++) tick(1);
    req_n = 1'b1; tick(1);
    chk("R7 early release", {gnt, ras_n, cas_n}, 3'b011);
    tick(10);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

endmodule